// File: doc/BRIEF.md
# Floating-Point Arithmetic Instruction Decode Stage

This block is a single registered pipeline stage that decodes 32-bit floating-point coprocessor data-processing instruction words. A word is offered together with an input valid strobe. One clock later the stage presents an output valid strobe, a 4-bit operation code, a precision flag, an undefined-instruction flag, three expanded register indices (destination, first source, second source) and, for the move-immediate form, the raw 8-bit immediate taken from the word.

Register indices in this instruction class are split across the word. Each one has a 4-bit field and a separate extra bit. The precision bit decides how the two are joined: in single precision the extra bit becomes the low index bit, and in double precision it becomes bit 5 with bit 0 forced to zero. The operation comes from a primary field that is masked before use, refined by a secondary field and a two-bit tertiary field. Reading the register file, widening the immediate into a floating-point constant and executing the operation belong to later stages.

Top module: `fp_dp_decoder`

## Requirements
- R1: `outValid` is low after a synchronous active-high `rst`. On each clock edge without reset, `outValid` takes the value that `inValid` had in the cycle before, so an accepted word appears after exactly one clock.
- R2: While `inValid` is low, `opCode`, `isDouble`, `undef`, `dstIdx`, `srcAIdx`, `srcBIdx` and `imm8` keep their previous values whatever `instr` carries.
- R3: `isDouble` equals instruction bit 8. When bit 8 is 0 (single), the indices are `dstIdx = {0, instr[15:12], instr[22]}`, `srcAIdx = {0, instr[19:16], instr[7]}` and `srcBIdx = {0, instr[3:0], instr[5]}`.
- R4: When bit 8 is 1 (double), the indices are `dstIdx = {instr[22], instr[15:12], 0}`, `srcAIdx = {instr[7], instr[19:16], 0}` and `srcBIdx = {instr[5], instr[3:0], 0}`.
- R5: Operation codes: 0 undefined, 1 multiply-accumulate, 2 multiply-subtract, 3 negated multiply-accumulate, 4 negated multiply-subtract, 5 multiply, 6 negated multiply, 7 add, 8 subtract, 9 divide, 10 move immediate, 11 move register, 12 absolute, 13 negate, 14 square root. The primary value P is `instr[23:20] & 4'b1011`, and T is `instr[7:6]`. P=0 gives code 1 when instr[6]=0 and code 2 when it is 1. P=1 gives code 3 when instr[6]=1 and code 4 when it is 0.
- R6: P=2 gives code 5 when T[0]=0 and code 6 when T[0]=1. P=3 gives code 7 when T[0]=0 and code 8 when T[0]=1.
- R7: P=8 gives code 9 when T[0]=0 and code 0 when T[0]=1. Bit 22 does not take part in the selection.
- R8: P=11 with T[0]=0 gives code 10. `imm8` is then `{instr[19:16], instr[3:0]}`, and `srcAIdx` and `srcBIdx` are zero.
- R9: P=11 with T[0]=1 is resolved by S = `instr[19:16]`. S=0 gives code 11 when T=1 and code 12 otherwise. S=1 gives code 13 when T=1 and code 14 otherwise. For these four codes `srcAIdx` is zero.
- R10: Every other encoding gives code 0 with `undef` high, and then all three indices and `imm8` are zero. `undef` is low for every defined code.
- R11: `imm8` is zero for every code other than 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction word is offered this cycle |
| instr | input | 32 | Instruction word |
| outValid | output | 1 | Decoded result is valid |
| opCode | output | 4 | Operation code (encoding in R5) |
| isDouble | output | 1 | 1 for double precision, 0 for single |
| undef | output | 1 | Encoding is not a supported operation |
| dstIdx | output | 6 | Expanded destination register index |
| srcAIdx | output | 6 | Expanded first source register index |
| srcBIdx | output | 6 | Expanded second source register index |
| imm8 | output | 8 | Raw immediate for move immediate, else zero |

## Verification
A wrong selection in the control path shows up one clock after the word is accepted, as a bad `opCode` or a wrongly set `undef`. The bench catches it because it compares every field of every table entry in that cycle. A wrong index splice shows up in the same cycle: a misplaced extra bit gives an odd index in double precision or a set bit 5 in single precision. The zeroing strobes leave a nonzero field on an operand that the operation does not use. A fault in the capture enable appears only in the first cycle after `inValid` falls, so directed tests change `instr` while the strobe is low and then check that the outputs held.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  typedef enum logic [3:0] {
    OP_UNDEF   = 4'd0,
    OP_MACC    = 4'd1,
    OP_MSUB    = 4'd2,
    OP_NMACC   = 4'd3,
    OP_NMSUB   = 4'd4,
    OP_MUL     = 4'd5,
    OP_NMUL    = 4'd6,
    OP_ADD     = 4'd7,
    OP_SUB     = 4'd8,
    OP_DIV     = 4'd9,
    OP_MOVIMM  = 4'd10,
    OP_MOVREG  = 4'd11,
    OP_ABS     = 4'd12,
    OP_NEG     = 4'd13,
    OP_SQRT    = 4'd14
  } fpOp_t;

  // Strobes from control to datapath.
  typedef struct packed {
    fpOp_t op;
    logic  isUndef;
    logic  keepDst;
    logic  keepSrcA;
    logic  keepSrcB;
    logic  keepImm;
  } decodeCtl_t;

endpackage

// File: rtl/fpdec_ctrl.sv
module fpdec_ctrl
  import fpdec_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output decodeCtl_t         ctl
);

  localparam logic [3:0] PRI_MASK = 4'b1011;

  logic [3:0] priField;
  logic [3:0] secField;
  logic [1:0] terField;
  fpOp_t      opSel;
  logic       unusedCtlBits;

  assign priField = instr[23:20] & PRI_MASK;
  assign secField = instr[19:16];
  assign terField = instr[7:6];
  assign unusedCtlBits = ^{instr[INSTR_W-1:24], instr[15:8], instr[5:0]};

  always_comb begin
    opSel = OP_UNDEF;
    unique case (priField)
      4'h0: opSel = terField[0] ? OP_MSUB  : OP_MACC;
      4'h1: opSel = terField[0] ? OP_NMACC : OP_NMSUB;
      4'h2: opSel = terField[0] ? OP_NMUL  : OP_MUL;
      4'h3: opSel = terField[0] ? OP_SUB   : OP_ADD;
      4'h8: opSel = terField[0] ? OP_UNDEF : OP_DIV;
      4'hB: begin
        if (!terField[0]) begin
          opSel = OP_MOVIMM;
        end else begin
          case (secField)
            4'h0:    opSel = (terField == 2'd1) ? OP_MOVREG : OP_ABS;
            4'h1:    opSel = (terField == 2'd1) ? OP_NEG    : OP_SQRT;
            default: opSel = OP_UNDEF;
          endcase
        end
      end
      default: opSel = OP_UNDEF;
    endcase
  end

  always_comb begin
    ctl.op       = opSel;
    ctl.isUndef  = (opSel == OP_UNDEF);
    ctl.keepDst  = (opSel != OP_UNDEF);
    ctl.keepSrcA = (opSel >= OP_MACC) && (opSel <= OP_DIV);
    ctl.keepSrcB = ((opSel >= OP_MACC) && (opSel <= OP_DIV)) ||
                   ((opSel >= OP_MOVREG) && (opSel <= OP_SQRT));
    ctl.keepImm  = (opSel == OP_MOVIMM);
  end

endmodule

// File: rtl/fpdec_datapath.sv
module fpdec_datapath
  import fpdec_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int FLD_W   = 4,
  localparam int IDX_W  = FLD_W + 2,
  localparam int IMM_W  = 2 * FLD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [INSTR_W-1:0] instr,
  input  decodeCtl_t        ctl,
  output logic              outValid,
  output logic [3:0]        opCode,
  output logic              isDouble,
  output logic              undef,
  output logic [IDX_W-1:0]  dstIdx,
  output logic [IDX_W-1:0]  srcAIdx,
  output logic [IDX_W-1:0]  srcBIdx,
  output logic [IMM_W-1:0]  imm8
);

  localparam int NUM_IDX  = 3;
  localparam int PREC_BIT = 8;

  // Operand slot 0: destination, 1: first source, 2: second source.
  function automatic int fieldLow(input int slot);
    case (slot)
      0:       return 12;
      1:       return 16;
      default: return 0;
    endcase
  endfunction

  function automatic int extraPos(input int slot);
    case (slot)
      0:       return 22;
      1:       return 7;
      default: return 5;
    endcase
  endfunction

  logic             dblSel;
  logic [IDX_W-1:0] expIdx  [NUM_IDX];
  logic [NUM_IDX-1:0] keepIdx;
  logic [IMM_W-1:0] immRaw;
  logic             unusedDpBits;

  assign dblSel  = instr[PREC_BIT];
  assign keepIdx = {ctl.keepSrcB, ctl.keepSrcA, ctl.keepDst};
  assign immRaw  = {instr[19:16], instr[3:0]};
  assign unusedDpBits = ^{instr[INSTR_W-1:23], instr[21:20], instr[11:9],
                          instr[6], instr[4]};

  for (genvar g = 0; g < NUM_IDX; g++) begin : gIdx
    localparam int LO = fieldLow(g);
    localparam int XP = extraPos(g);
    logic [FLD_W-1:0] fld;
    logic             xBit;
    assign fld  = instr[LO +: FLD_W];
    assign xBit = instr[XP];
    always_comb begin
      if (!keepIdx[g]) begin
        expIdx[g] = '0;
      end else if (dblSel) begin
        expIdx[g] = {xBit, fld, 1'b0};
      end else begin
        expIdx[g] = {1'b0, fld, xBit};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      opCode   <= '0;
      isDouble <= 1'b0;
      undef    <= 1'b0;
      dstIdx   <= '0;
      srcAIdx  <= '0;
      srcBIdx  <= '0;
      imm8     <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        opCode   <= ctl.op;
        isDouble <= dblSel;
        undef    <= ctl.isUndef;
        dstIdx   <= expIdx[0];
        srcAIdx  <= expIdx[1];
        srcBIdx  <= expIdx[2];
        imm8     <= ctl.keepImm ? immRaw : '0;
      end
    end
  end

endmodule

// File: rtl/fp_dp_decoder.sv
module fp_dp_decoder
  import fpdec_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int FLD_W   = 4,
  localparam int IDX_W  = FLD_W + 2,
  localparam int IMM_W  = 2 * FLD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instr,
  output logic               outValid,
  output logic [3:0]         opCode,
  output logic               isDouble,
  output logic               undef,
  output logic [IDX_W-1:0]   dstIdx,
  output logic [IDX_W-1:0]   srcAIdx,
  output logic [IDX_W-1:0]   srcBIdx,
  output logic [IMM_W-1:0]   imm8
);

  decodeCtl_t ctl;

  fpdec_ctrl #(.INSTR_W(INSTR_W)) uCtrl (
    .instr (instr),
    .ctl   (ctl)
  );

  fpdec_datapath #(.INSTR_W(INSTR_W), .FLD_W(FLD_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .instr    (instr),
    .ctl      (ctl),
    .outValid (outValid),
    .opCode   (opCode),
    .isDouble (isDouble),
    .undef    (undef),
    .dstIdx   (dstIdx),
    .srcAIdx  (srcAIdx),
    .srcBIdx  (srcBIdx),
    .imm8     (imm8)
  );

endmodule

// File: rtl/fpdec_checker.sv
module fpdec_checker #(
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 6,
  parameter int IMM_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [INSTR_W-1:0] instr,
  input logic               outValid,
  input logic [3:0]         opCode,
  input logic               isDouble,
  input logic               undef,
  input logic [IDX_W-1:0]   dstIdx,
  input logic [IDX_W-1:0]   srcAIdx,
  input logic [IDX_W-1:0]   srcBIdx,
  input logic [IMM_W-1:0]   imm8
);

  logic isDivGroup;
  assign isDivGroup = ((instr[23:20] & 4'b1011) == 4'h8);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(opCode) && $stable(dstIdx) && $stable(srcAIdx) &&
                  $stable(srcBIdx) && $stable(imm8) && $stable(undef))); // R2
  AST_SINGLE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (outValid && !isDouble) |->
      (!dstIdx[IDX_W-1] && !srcAIdx[IDX_W-1] && !srcBIdx[IDX_W-1])); // R3
  AST_DOUBLE_EVEN: assert property (@(posedge clk) disable iff (rst)
    (outValid && isDouble) |-> (!dstIdx[0] && !srcAIdx[0] && !srcBIdx[0])); // R4
  AST_DIV_SELECT: assert property (@(posedge clk) disable iff (rst)
    (inValid && isDivGroup) |=>
      (opCode == ($past(instr[6]) ? 4'd0 : 4'd9))); // R7
  AST_MOVIMM_SRC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (outValid && opCode == 4'd10) |-> (srcAIdx == '0 && srcBIdx == '0)); // R8
  AST_TWO_OP_SRCA_ZERO: assert property (@(posedge clk) disable iff (rst)
    (outValid && opCode >= 4'd11 && opCode <= 4'd14) |-> (srcAIdx == '0)); // R9
  AST_UNDEF_FLAG: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (undef == (opCode == 4'd0))); // R10
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (outValid && undef) |->
      (dstIdx == '0 && srcAIdx == '0 && srcBIdx == '0 && imm8 == '0)); // R10
  AST_IMM_ONLY_MOVE: assert property (@(posedge clk) disable iff (rst)
    (outValid && opCode != 4'd10) |-> (imm8 == '0)); // R11

endmodule

bind fp_dp_decoder fpdec_checker #(
  .INSTR_W(INSTR_W), .IDX_W(IDX_W), .IMM_W(IMM_W)
) uChk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .instr    (instr),
  .outValid (outValid),
  .opCode   (opCode),
  .isDouble (isDouble),
  .undef    (undef),
  .dstIdx   (dstIdx),
  .srcAIdx  (srcAIdx),
  .srcBIdx  (srcBIdx),
  .imm8     (imm8)
);

// File: tb/tb_fp_dp_decoder.sv
`timescale 1ns/1ps
module tb_fp_dp_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic        outValid, isDouble, undef;
  logic [3:0]  opCode;
  logic [5:0]  dstIdx, srcAIdx, srcBIdx;
  logic [7:0]  imm8;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fp_dp_decoder dut (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr),
    .outValid(outValid), .opCode(opCode), .isDouble(isDouble), .undef(undef),
    .dstIdx(dstIdx), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .imm8(imm8)
  );

  typedef struct packed {
    logic [3:0] pri;
    logic       dBit;
    logic [3:0] vn;
    logic [3:0] vd;
    logic       sz;
    logic       nBit;
    logic       t0;
    logic       mBit;
    logic [3:0] vm;
    logic [3:0] eOp;
    logic [5:0] eDst;
    logic [5:0] eA;
    logic [5:0] eB;
    logic [7:0] eImm;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{4'h0,1'b1,4'd3,4'd5,1'b0,1'b1,1'b0,1'b0,4'd9, 4'd1, 6'd11,6'd7, 6'd18,8'h00},
    '{4'h0,1'b1,4'd3,4'd5,1'b1,1'b1,1'b1,1'b1,4'd9, 4'd2, 6'd42,6'd38,6'd50,8'h00},
    '{4'h1,1'b0,4'd15,4'd15,1'b0,1'b0,1'b1,1'b1,4'd0,4'd3, 6'd30,6'd30,6'd1, 8'h00},
    '{4'h1,1'b0,4'd2,4'd7,1'b1,1'b0,1'b0,1'b0,4'd4, 4'd4, 6'd14,6'd4, 6'd8, 8'h00},
    '{4'h2,1'b1,4'd15,4'd15,1'b0,1'b1,1'b0,1'b1,4'd15,4'd5,6'd31,6'd31,6'd31,8'h00},
    '{4'h2,1'b1,4'd15,4'd15,1'b1,1'b1,1'b1,1'b1,4'd15,4'd6,6'd62,6'd62,6'd62,8'h00},
    '{4'h3,1'b0,4'd1,4'd2,1'b0,1'b0,1'b0,1'b0,4'd3, 4'd7, 6'd4, 6'd2, 6'd6, 8'h00},
    '{4'h3,1'b0,4'd1,4'd2,1'b1,1'b0,1'b1,1'b1,4'd3, 4'd8, 6'd4, 6'd2, 6'd38,8'h00},
    '{4'h8,1'b0,4'd6,4'd1,1'b0,1'b1,1'b0,1'b0,4'd2, 4'd9, 6'd2, 6'd13,6'd4, 8'h00},
    '{4'h8,1'b0,4'd6,4'd1,1'b0,1'b1,1'b1,1'b0,4'd2, 4'd0, 6'd0, 6'd0, 6'd0, 8'h00},
    '{4'h8,1'b1,4'd0,4'd0,1'b1,1'b0,1'b0,1'b1,4'd0, 4'd9, 6'd32,6'd0, 6'd32,8'h00},
    '{4'hB,1'b0,4'hA,4'd3,1'b0,1'b1,1'b0,1'b1,4'h5, 4'd10,6'd6, 6'd0, 6'd0, 8'hA5},
    '{4'hB,1'b1,4'hF,4'd0,1'b1,1'b0,1'b0,1'b0,4'h0, 4'd10,6'd32,6'd0, 6'd0, 8'hF0},
    '{4'hB,1'b0,4'd0,4'd4,1'b0,1'b0,1'b1,1'b1,4'd6, 4'd11,6'd8, 6'd0, 6'd13,8'h00},
    '{4'hB,1'b0,4'd0,4'd4,1'b1,1'b1,1'b1,1'b0,4'd6, 4'd12,6'd8, 6'd0, 6'd12,8'h00},
    '{4'hB,1'b1,4'd1,4'd0,1'b0,1'b0,1'b1,1'b0,4'd7, 4'd13,6'd1, 6'd0, 6'd14,8'h00},
    '{4'hB,1'b1,4'd1,4'd0,1'b1,1'b1,1'b1,1'b1,4'd7, 4'd14,6'd32,6'd0, 6'd46,8'h00},
    '{4'hB,1'b0,4'd2,4'd3,1'b0,1'b0,1'b1,1'b1,4'd3, 4'd0, 6'd0, 6'd0, 6'd0, 8'h00},
    '{4'h9,1'b0,4'd2,4'd3,1'b0,1'b0,1'b0,1'b1,4'd3, 4'd0, 6'd0, 6'd0, 6'd0, 8'h00},
    '{4'hA,1'b1,4'd2,4'd3,1'b1,1'b1,1'b0,1'b1,4'd3, 4'd0, 6'd0, 6'd0, 6'd0, 8'h00}
  };

  function automatic logic [31:0] mkWord(input vec_t v);
    logic [31:0] w;
    w = 32'hEE000A00;
    w[23:20] = v.pri;
    w[22]    = v.dBit;
    w[19:16] = v.vn;
    w[15:12] = v.vd;
    w[8]     = v.sz;
    w[7]     = v.nBit;
    w[6]     = v.t0;
    w[5]     = v.mBit;
    w[3:0]   = v.vm;
    return w;
  endfunction

  function automatic string opReq(input logic [3:0] op);
    if (op == 4'd0) return "R10";
    if (op <= 4'd4) return "R5";
    if (op <= 4'd8) return "R6";
    if (op == 4'd9) return "R7";
    if (op == 4'd10) return "R8";
    return "R9";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkVec(input vec_t v);
    string idxReq;
    idxReq = (v.eOp == 4'd0) ? "R10" : (v.sz ? "R4" : "R3");
    check("R1", "outValid", {31'd0, outValid}, 32'd1);
    check(opReq(v.eOp), "opCode", {28'd0, opCode}, {28'd0, v.eOp});
    check("R3", "isDouble", {31'd0, isDouble}, {31'd0, v.sz});
    check("R10", "undef", {31'd0, undef}, {31'd0, (v.eOp == 4'd0)});
    check(idxReq, "dstIdx", {26'd0, dstIdx}, {26'd0, v.eDst});
    check((v.eOp >= 4'd10) ? opReq(v.eOp) : idxReq, "srcAIdx",
          {26'd0, srcAIdx}, {26'd0, v.eA});
    check((v.eOp == 4'd10) ? "R8" : idxReq, "srcBIdx",
          {26'd0, srcBIdx}, {26'd0, v.eB});
    check((v.eOp == 4'd10) ? "R8" : "R11", "imm8",
          {24'd0, imm8}, {24'd0, v.eImm});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "outValid after reset", {31'd0, outValid}, 32'd0);
    rst = 1'b0;

    // Back-to-back table walk: drive on one falling edge, check on the next.
    @(negedge clk);
    inValid = 1'b1;
    instr = mkWord(TBL[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      checkVec(TBL[i]);
      if (i + 1 < NV) instr = mkWord(TBL[i + 1]);
    end

    // R2: strobe low, new word offered; outputs keep the last table entry.
    inValid = 1'b0;
    instr = mkWord(TBL[11]);
    @(negedge clk);
    check("R1", "outValid idle", {31'd0, outValid}, 32'd0);
    check("R2", "opCode hold", {28'd0, opCode}, {28'd0, TBL[NV-1].eOp});
    check("R2", "dstIdx hold", {26'd0, dstIdx}, {26'd0, TBL[NV-1].eDst});
    check("R2", "imm8 hold", {24'd0, imm8}, {24'd0, TBL[NV-1].eImm});
    check("R2", "undef hold", {31'd0, undef}, 32'd1);

    // Single word after idle gap (R1 latency).
    inValid = 1'b1;
    instr = mkWord(TBL[15]);
    @(negedge clk);
    inValid = 1'b0;
    checkVec(TBL[15]);
    @(negedge clk);
    check("R1", "outValid pulse ends", {31'd0, outValid}, 32'd0);
    check("R2", "srcBIdx hold", {26'd0, srcBIdx}, {26'd0, TBL[15].eB});

    // Reset while a word is offered clears outValid (R1).
    inValid = 1'b1;
    instr = mkWord(TBL[4]);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "outValid under reset", {31'd0, outValid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    checkVec(TBL[4]);
    inValid = 1'b0;
    @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(100000 * 4);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule